// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Unit

This block watches up to 32 general-purpose input pins and turns selected signal transitions into one interrupt request. Each pin passes through a synchronizer. The synchronized value is then compared with its value one clock earlier, which finds 0-to-1 and 1-to-0 transitions. Two independent per-pin enable vectors choose which transitions count. A qualifying transition sets a sticky cause bit for that pin. The cause bit stays set until software clears it.

An event mask decides which cause bits may reach the interrupt output. Software can read the masked causes through a status register. It acknowledges an event by writing ones to a clear register. Before a pin's mask bit is set, software should clear that pin's stale cause, so that an old event does not raise the interrupt at once.

The register port is a simple single-cycle bus with separate write and read strobes. Read data appears one cycle after the read strobe. The interrupt output is a registered level.

Top module: `gpio_evt_unit`

## Requirements
- R1: When bit i of the rise-enable register (offset 0x44) is 1, a 0-to-1 transition of synchronized pin i sets cause bit i. When that bit is 0, a rising transition leaves the cause unchanged.
- R2: When bit i of the fall-enable register (offset 0x48) is 1, a 1-to-0 transition of synchronized pin i sets cause bit i. When that bit is 0, a falling transition leaves the cause unchanged.
- R3: When both enables of a pin are 1, either transition sets its cause. When neither enable is 1, no transition sets its cause.
- R4: Cause bits are captured whatever the value of the event mask (offset 0x94). Only cause bits whose mask bit is 1 can drive the interrupt. A cause captured while masked raises the interrupt once its mask bit is set.
- R5: A read of offset 0x80 returns the cause bits ANDed with the event mask. Writes to 0x80 have no effect.
- R6: Writing 1 to bit i of offset 0x98 clears cause bit i. Writing 0 leaves that bit unchanged. Offset 0x98 reads as 0.
- R7: If a qualifying transition and a clear of the same bit take effect in the same cycle, the cause bit ends up set.
- R8: irq_out is a registered OR of all masked cause bits. It stays high until every masked cause is cleared or masked off.
- R9: After a synchronous active-low reset, the rise-enable, fall-enable, mask and cause registers are 0 and irq_out is 0. Offsets 0x44, 0x48 and 0x94 read back the last value written to them.
- R10: Read data is valid in the cycle after the read strobe. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd_en |
| pin_in | input | NPINS | Asynchronous pin inputs |
| irq_out | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check these rules:
- A cause bit rises only with a detected transition.
- A cause bit falls only under a clear.
- A cleared bit drops unless a new transition arrives.
- A transition always wins over a clear.
- irq_out follows the masked causes one cycle later.

Other behaviour can only be shown by the bench's scenarios:
- the register offsets and their read-back;
- the choice of transition direction through the enables;
- capture while masked, and the stale-cause sequence;
- the timing of a transition and a clear landing in the same cycle;
- writes to the status register being ignored.

// File: rtl/gpio_evt_pkg.sv
// Package: shared register offsets and widths for the edge interrupt cause unit.
// Assumes byte offsets that fit in ADDR_W bits and a 32-bit data path.
package gpio_evt_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_RISE_EN = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_FALL_EN = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_EVT_MSK = 8'h94;
    localparam logic [ADDR_W-1:0] OFS_CLEAR   = 8'h98;
endpackage

// File: rtl/gpio_evt_sync.sv
// Module: multi-stage synchronizer for the pin inputs.
// Assumes the pins are asynchronous to clk and at least two stages are used.
module gpio_evt_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d_async,
    output logic [NPINS-1:0] q_sync
);
    logic [NPINS-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Purpose: shift the pin sample one stage down the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[g] <= '0;
            end else if (g == 0) begin
                stg[g] <= d_async;
            end else begin
                stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/gpio_evt_edge.sv
// Module: transition detector with per-pin direction enables.
// Compares the synchronized value with its value one clock earlier.
// Assumes the input is already synchronous to clk.
module gpio_evt_edge #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sync_in,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    output logic [NPINS-1:0] set_vec
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] went_up;
    logic [NPINS-1:0] went_dn;

    // Purpose: remember the last synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    // Purpose: qualify the raw transitions with the direction enables.
    always_comb begin
        went_up = sync_in & ~prev_q;
        went_dn = ~sync_in & prev_q;
        set_vec = (went_up & rise_en) | (went_dn & fall_en);
    end
endmodule

// File: rtl/gpio_evt_cause.sv
// Module: sticky cause bits with write-one-to-clear.
// A set request wins over a clear of the same bit in the same cycle.
// Assumes set and clear requests are one-cycle pulses.
module gpio_evt_cause #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] set_vec,
    input  logic [NPINS-1:0] clr_vec,
    output logic [NPINS-1:0] cause_q
);
    // Purpose: hold the causes, clear the acknowledged bits, then apply new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_vec) | set_vec;
    end

    // R2 R1: a cause bit rises only together with a detected transition
    a_r1_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_vec)) == '0));
    // R6: a cause bit falls only under a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cause_q) & ~cause_q & ~$past(clr_vec)) == '0));
    // R6: a cleared bit with no new transition is gone
    a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(clr_vec & ~set_vec)) == '0));
    // R7: a transition wins over a clear
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/gpio_evt_regs.sv
// Module: register decode for the enables, the mask, the status and the clear.
// Read data is registered and valid one cycle after rd_en.
// Assumes wr_en and rd_en are single-cycle strobes.
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPINS-1:0]  cause_q,
    output logic [NPINS-1:0]  rise_en,
    output logic [NPINS-1:0]  fall_en,
    output logic [NPINS-1:0]  evt_mask,
    output logic [NPINS-1:0]  clr_vec,
    output logic [DATA_W-1:0] rdata
);
    logic [NPINS-1:0]  wbits;
    logic [DATA_W-1:0] rd_mux;

    assign wbits = wdata[NPINS-1:0];

    // Purpose: update the writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en  <= '0;
            fall_en  <= '0;
            evt_mask <= '0;
        end else if (wr_en) begin
            if (addr == OFS_RISE_EN) rise_en  <= wbits;
            if (addr == OFS_FALL_EN) fall_en  <= wbits;
            if (addr == OFS_EVT_MSK) evt_mask <= wbits;
        end
    end

    // Purpose: turn a write to the clear offset into a one-cycle clear pulse.
    always_comb begin
        clr_vec = (wr_en && addr == OFS_CLEAR) ? wbits : '0;
    end

    // Purpose: select the read value by offset.
    always_comb begin
        unique case (addr)
            OFS_RISE_EN: rd_mux = DATA_W'(rise_en);
            OFS_FALL_EN: rd_mux = DATA_W'(fall_en);
            OFS_EVT_MSK: rd_mux = DATA_W'(evt_mask);
            OFS_STATUS:  rd_mux = DATA_W'(cause_q & evt_mask);
            default:     rd_mux = '0;
        endcase
    end

    // Purpose: register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R5: a write to the status offset changes no configuration register
    a_r5_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STATUS) |=> ($stable(rise_en) && $stable(fall_en) && $stable(evt_mask)));
endmodule

// File: rtl/gpio_evt_unit.sv
// Module: top of the GPIO edge interrupt cause unit.
// Chain: synchronizer -> transition detector -> sticky causes -> masked OR -> irq_out.
// Assumes NPINS <= 32 and an asynchronous pin input.
module gpio_evt_unit
    import gpio_evt_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic              irq_out
);
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] rise_en;
    logic [NPINS-1:0] fall_en;
    logic [NPINS-1:0] evt_mask;
    logic [NPINS-1:0] set_vec;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] cause_q;
    logic             any_masked;

    gpio_evt_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_sync));

    gpio_evt_edge #(.NPINS(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(pin_sync),
        .rise_en(rise_en), .fall_en(fall_en), .set_vec(set_vec));

    gpio_evt_cause #(.NPINS(NPINS)) u_cause (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_vec(clr_vec), .cause_q(cause_q));

    gpio_evt_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
        .addr(bus_addr), .wdata(bus_wdata), .cause_q(cause_q),
        .rise_en(rise_en), .fall_en(fall_en), .evt_mask(evt_mask),
        .clr_vec(clr_vec), .rdata(bus_rdata));

    assign any_masked = |(cause_q & evt_mask);

    // Purpose: register the aggregated interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= any_masked;
    end

    // R8: the interrupt follows the masked causes one cycle later
    a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(cause_q & evt_mask))));
    // R9: reset leaves the interrupt low
    a_r9_reset_irq: assert property (@(posedge clk)
        !rst_n |=> !irq_out);
    // R4: with the mask at zero the interrupt cannot rise
    a_r4_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mask == '0) |=> !irq_out);
endmodule

// File: tb/sim_gpio_evt_unit.sv
// Scoreboard bench: the read driver pushes expected data; the monitor pops and compares.
module sim_gpio_evt_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    gpio_evt_unit #(.NPINS(NP), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .irq_out(irq_out));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Monitor: note a read strobe at the edge, compare at the following falling edge (R10).
    always @(posedge clk) rd_seen <= bus_rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks = checks + 1;
            if (bus_rdata !== e) begin
                failures = failures + 1;
                $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks = checks + 1;
        if (irq_out !== e) begin
            failures = failures + 1;
            $display("FAIL %s irq actual=%b expected=%b", t, irq_out, e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pin_in[p] = v;
        idle(6);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R9: reset state
        rd(8'h44, 32'h0, "R9 rise reset");
        rd(8'h48, 32'h0, "R9 fall reset");
        rd(8'h94, 32'h0, "R9 mask reset");
        rd(8'h80, 32'h0, "R9 status reset");
        chk_irq(1'b0, "R9 irq reset");

        // R1: rising edge with the rise enable on
        wr(8'h44, 32'h0000_0001);
        wr(8'h94, 32'h0000_0001);
        set_pin(0, 1'b1);
        chk_irq(1'b1, "R1 rise sets irq");
        rd(8'h80, 32'h0000_0001, "R1 status");
        // R8: the level holds
        idle(10);
        chk_irq(1'b1, "R8 irq held");
        // R6: zero write keeps the cause, one write clears it, the clear offset reads 0
        wr(8'h98, 32'h0000_0000);
        idle(2);
        chk_irq(1'b1, "R6 zero write no clear");
        wr(8'h98, 32'h0000_0001);
        idle(2);
        chk_irq(1'b0, "R6 one write clears");
        rd(8'h80, 32'h0, "R6 status after clear");
        rd(8'h98, 32'h0, "R6 clear reads zero");
        // R1: falling edge with only the rise enable on sets nothing
        set_pin(0, 1'b0);
        chk_irq(1'b0, "R1 fall ignored");
        rd(8'h80, 32'h0, "R1 fall ignored status");

        // R2: falling edge only
        wr(8'h48, 32'h0000_0008);
        wr(8'h94, 32'h0000_0009);
        set_pin(3, 1'b1);
        rd(8'h80, 32'h0, "R2 rise ignored");
        set_pin(3, 1'b0);
        rd(8'h80, 32'h0000_0008, "R2 fall sets");
        chk_irq(1'b1, "R2 irq");
        wr(8'h98, 32'h0000_0008);

        // R3: both enables give either edge; no enable gives nothing
        wr(8'h44, 32'h0000_0021);
        wr(8'h48, 32'h0000_0028);
        wr(8'h94, 32'h0000_0421);
        set_pin(5, 1'b1);
        rd(8'h80, 32'h0000_0020, "R3 both rise");
        wr(8'h98, 32'h0000_0020);
        set_pin(5, 1'b0);
        rd(8'h80, 32'h0000_0020, "R3 both fall");
        wr(8'h98, 32'h0000_0020);
        set_pin(10, 1'b1);
        set_pin(10, 1'b0);
        rd(8'h80, 32'h0, "R3 no enable");
        chk_irq(1'b0, "R3 no enable irq");

        // R4: capture while masked, then stale-cause handling
        wr(8'h44, 32'h0000_0080);
        wr(8'h94, 32'h0000_0000);
        set_pin(7, 1'b1);
        chk_irq(1'b0, "R4 masked no irq");
        rd(8'h80, 32'h0, "R4 masked status");
        wr(8'h94, 32'h0000_0080);
        idle(2);
        chk_irq(1'b1, "R4 captured while masked");
        rd(8'h80, 32'h0000_0080, "R4 status unmasked");
        wr(8'h94, 32'h0000_0000);
        wr(8'h98, 32'h0000_0080);
        wr(8'h94, 32'h0000_0080);
        idle(2);
        chk_irq(1'b0, "R4 stale cleared first");

        // R5: writes to status are ignored
        set_pin(7, 1'b0);
        set_pin(7, 1'b1);
        wr(8'h80, 32'h0000_0000);
        rd(8'h80, 32'h0000_0080, "R5 status write ignored");
        chk_irq(1'b1, "R5 irq unchanged");
        rd(8'h44, 32'h0000_0080, "R9 rise readback");
        rd(8'h94, 32'h0000_0080, "R9 mask readback");
        wr(8'h98, 32'h0000_0080);

        // R7: transition and clear land in the same cycle
        wr(8'h44, 32'h0000_0100);
        wr(8'h94, 32'h0000_0100);
        idle(2);
        chk_irq(1'b0, "R7 before");
        @(negedge clk);
        pin_in[8] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 8'h98; bus_wdata = 32'h0000_0100;
        @(negedge clk);
        bus_wr_en = 1'b0;
        idle(2);
        chk_irq(1'b1, "R7 edge wins");
        rd(8'h80, 32'h0000_0100, "R7 status");

        // R10: unmapped offset
        rd(8'h10, 32'h0, "R10 unmapped");
        rd(8'h4C, 32'h0, "R10 unmapped2");

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule